// File: doc/BRIEF.md
# Two-Cache Write-Through Coherence Controller

This block keeps two small direct-mapped caches coherent on a shared bus. Each cache serves one processor. A line is either holding a usable copy or holding nothing usable: there is no dirty state. Every processor store goes to memory in the same bus cycle that services it. The same store removes any copy of that address from the other cache. Loads that hit are served from the cache without touching the bus. Loads that miss fetch the word from memory and allocate the line. An evict request drops the line locally and generates no bus traffic.

Each processor holds `pN_req` with an operation, an address and store data until `pN_done` pulses for one cycle. At most one bus transaction happens per cycle. When both caches need the bus in the same cycle, the cache that was not granted most recently goes first, and the other one follows in the next cycle. Memory sits outside the block and is reached through a simple port: the word at `mem_addr` is returned combinationally, and a store is committed at the clock edge. A lookup port lets the surrounding logic observe whether either cache holds a given address, and the value it holds.

Top module: `wt_snoop_pair`

## Requirements
- R1: After reset no line in either cache holds a usable copy, both done outputs are low and no bus transaction is issued.
- R2: A request is serviced at a clock edge, and `pN_done` is high for exactly one cycle after that edge. Operation codes are 2'b00 load, 2'b01 store, and 2'b10 or 2'b11 evict. A load that misses drives `mem_req` with `mem_we` low, returns the memory word on `pN_rdata` and leaves the line valid with that word. Memory is unchanged.
- R3: A load that hits returns the cached word, raises no `mem_req`, and leaves the line valid.
- R4: A store drives `mem_req` and `mem_we` with its address and data, so memory holds the new word after the edge. The storing cache ends with the line valid and holding the new word, including when the line missed or held another tag.
- R5: A store by one cache to an address the other cache holds invalidates the other cache's line at the same edge. A later load by that cache misses and returns the updated memory word.
- R6: An evict whose address matches a held line invalidates that line without a bus transaction. An evict whose tag does not match leaves the line unchanged.
- R7: When both caches need the bus in the same cycle, the cache not granted most recently is served first, and the other is served in the next cycle. Two stores contending for one address leave memory and the only valid copy with the later store's value.
- R8: Snooping compares the full tag. A remote store to a different address that maps to the same index leaves the line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req | input | 1 | Processor 0 request, held until done |
| p0_op | input | 2 | Processor 0 operation (00 load, 01 store, 1x evict) |
| p0_addr | input | AW | Processor 0 word address |
| p0_wdata | input | DW | Processor 0 store data |
| p0_done | output | 1 | Processor 0 completion pulse |
| p0_rdata | output | DW | Processor 0 load result |
| p1_req | input | 1 | Processor 1 request, held until done |
| p1_op | input | 2 | Processor 1 operation |
| p1_addr | input | AW | Processor 1 word address |
| p1_wdata | input | DW | Processor 1 store data |
| p1_done | output | 1 | Processor 1 completion pulse |
| p1_rdata | output | DW | Processor 1 load result |
| mem_req | output | 1 | Bus transaction this cycle |
| mem_we | output | 1 | Bus transaction is a store |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus store data |
| mem_rdata | input | DW | Memory word at mem_addr |
| look_addr | input | AW | Address to observe |
| look_v0 | output | 1 | Cache 0 holds look_addr |
| look_d0 | output | DW | Cache 0 word at the look_addr index |
| look_v1 | output | 1 | Cache 1 holds look_addr |
| look_d1 | output | DW | Cache 1 word at the look_addr index |

## Verification
The bench replays a five-step sequence of loads, read-modify-write stores and a reload on one shared address. After each step it checks both caches and memory. If invalidation were missing, the final load would return the stale word 10 or 12 instead of 24. The bench sends a remote store to an alias address on the same index; a design comparing only the index would drop an unrelated line. It issues an evict with a mismatched tag, which a careless design would also invalidate. It arranges simultaneous bus requests after each cache in turn was granted last; a fixed-priority arbiter would serve cache 0 first both times. Two stores to one address in the same cycle expose any order in which the earlier writer keeps a valid copy.

// File: rtl/wt_snoop_pair.sv
module wt_snoop_pair #(
  parameter int AW = 6,
  parameter int IW = 2,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p0_req,
  input  logic [1:0]    p0_op,
  input  logic [AW-1:0] p0_addr,
  input  logic [DW-1:0] p0_wdata,
  output logic          p0_done,
  output logic [DW-1:0] p0_rdata,
  input  logic          p1_req,
  input  logic [1:0]    p1_op,
  input  logic [AW-1:0] p1_addr,
  input  logic [DW-1:0] p1_wdata,
  output logic          p1_done,
  output logic [DW-1:0] p1_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] look_addr,
  output logic          look_v0,
  output logic [DW-1:0] look_d0,
  output logic          look_v1,
  output logic [DW-1:0] look_d1
);
  localparam int NL = 1 << IW;
  localparam int TW = AW - IW;
  localparam logic [1:0] OP_RD = 2'b00;
  localparam logic [1:0] OP_WR = 2'b01;

  logic [NL-1:0] vld  [2];
  logic [TW-1:0] tagm [2][NL];
  logic [DW-1:0] dat  [2][NL];

  logic [1:0]    req, done_q, act, hit, need, gnt, srv;
  logic [1:0]    op   [2];
  logic [AW-1:0] ad   [2];
  logic [DW-1:0] wd   [2];
  logic [DW-1:0] rd_q [2];
  logic [IW-1:0] idx  [2];
  logic [TW-1:0] tg   [2];
  logic          last_q, gsel;

  assign req   = {p1_req, p0_req};
  assign op[0] = p0_op;    assign op[1] = p1_op;
  assign ad[0] = p0_addr;  assign ad[1] = p1_addr;
  assign wd[0] = p0_wdata; assign wd[1] = p1_wdata;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      idx[c]  = ad[c][IW-1:0];
      tg[c]   = ad[c][AW-1:IW];
      hit[c]  = vld[c][idx[c]] && (tagm[c][idx[c]] == tg[c]);
      act[c]  = req[c] && !done_q[c];
      need[c] = act[c] && (op[c] == OP_WR || (op[c] == OP_RD && !hit[c]));
    end
    gnt = need;
    if (&need) gnt = last_q ? 2'b01 : 2'b10;
    srv = act & (~need | gnt);
  end

  assign gsel      = gnt[1];
  assign mem_req   = |gnt;
  assign mem_we    = mem_req && (op[gsel] == OP_WR);
  assign mem_addr  = ad[gsel];
  assign mem_wdata = wd[gsel];

  assign p0_done  = done_q[0];
  assign p1_done  = done_q[1];
  assign p0_rdata = rd_q[0];
  assign p1_rdata = rd_q[1];

  logic [IW-1:0] lidx;
  logic [TW-1:0] ltag;
  assign lidx    = look_addr[IW-1:0];
  assign ltag    = look_addr[AW-1:IW];
  assign look_v0 = vld[0][lidx] && (tagm[0][lidx] == ltag);
  assign look_v1 = vld[1][lidx] && (tagm[1][lidx] == ltag);
  assign look_d0 = dat[0][lidx];
  assign look_d1 = dat[1][lidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) vld[c] <= '0;
      done_q <= '0;
      last_q <= 1'b1;
    end else begin
      done_q <= srv;
      if (mem_req) last_q <= gsel;
      for (int c = 0; c < 2; c++) begin
        if (srv[c]) begin
          if (op[c] == OP_RD || op[c] == OP_WR) vld[c][idx[c]] <= 1'b1;
          else if (hit[c])                      vld[c][idx[c]] <= 1'b0;
        end
        if (mem_we && gnt[c^1] && vld[c][idx[c^1]] && tagm[c][idx[c^1]] == tg[c^1])
          vld[c][idx[c^1]] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (srv[c] && op[c] == OP_RD) begin
        if (hit[c]) rd_q[c] <= dat[c][idx[c]];
        else begin
          rd_q[c]         <= mem_rdata;
          dat[c][idx[c]]  <= mem_rdata;
          tagm[c][idx[c]] <= tg[c];
        end
      end else if (srv[c] && op[c] == OP_WR) begin
        dat[c][idx[c]]  <= wd[c];
        tagm[c][idx[c]] <= tg[c];
      end
    end
  end

  logic          wr_q, wr_src_q;
  logic [AW-1:0] wr_addr_q;
  logic [DW-1:0] wr_data_q;
  logic [1:0]    fill_q;
  logic [AW-1:0] fill_addr_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      fill_q <= '0;
    end else begin
      wr_q      <= mem_we;
      wr_src_q  <= gsel;
      wr_addr_q <= mem_addr;
      wr_data_q <= mem_wdata;
      fill_q    <= gnt & {~mem_we, ~mem_we};
      fill_addr_q[0] <= ad[0];
      fill_addr_q[1] <= ad[1];
    end
  end

  logic [IW-1:0] wi;
  logic [TW-1:0] wt;
  logic          own_ok, oth_holds;
  logic [1:0]    fill_ok;
  assign wi        = wr_addr_q[IW-1:0];
  assign wt        = wr_addr_q[AW-1:IW];
  assign own_ok    = vld[wr_src_q][wi] && tagm[wr_src_q][wi] == wt && dat[wr_src_q][wi] == wr_data_q;
  assign oth_holds = vld[!wr_src_q][wi] && tagm[!wr_src_q][wi] == wt;
  assign fill_ok[0] = vld[0][fill_addr_q[0][IW-1:0]] && dat[0][fill_addr_q[0][IW-1:0]] == rd_q[0];
  assign fill_ok[1] = vld[1][fill_addr_q[1][IW-1:0]] && dat[1][fill_addr_q[1][IW-1:0]] == rd_q[1];

  assert_store_alloc_R4: assert property (@(posedge clk) disable iff (!rst_n) wr_q |-> own_ok);
  assert_snoop_inval_R5: assert property (@(posedge clk) disable iff (!rst_n) wr_q |-> !oth_holds);
  assert_fill_match_R2: assert property (@(posedge clk) disable iff (!rst_n) |fill_q |-> (fill_ok | ~fill_q) == 2'b11);
  assert_done_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n) done_q[0] |-> $past(req[0]));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n) done_q[1] |=> !done_q[1]);
endmodule

// File: tb/wt_snoop_pair_tb_top.sv
module wt_snoop_pair_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          p0_req = 0, p1_req = 0;
  logic [1:0]    p0_op = 0, p1_op = 0;
  logic [AW-1:0] p0_addr = 0, p1_addr = 0, look_addr = 0;
  logic [DW-1:0] p0_wdata = 0, p1_wdata = 0;
  logic          p0_done, p1_done, mem_req, mem_we, look_v0, look_v1;
  logic [DW-1:0] p0_rdata, p1_rdata, mem_wdata, mem_rdata, look_d0, look_d1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem [64];

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  wt_snoop_pair #(.AW(AW), .IW(2), .DW(DW)) dut_i (
    .clk, .rst_n,
    .p0_req, .p0_op, .p0_addr, .p0_wdata, .p0_done, .p0_rdata,
    .p1_req, .p1_op, .p1_addr, .p1_wdata, .p1_done, .p1_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .look_addr, .look_v0, .look_d0, .look_v1, .look_d1);

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic look(logic [AW-1:0] a);
    look_addr = a;
    #1;
  endtask

  logic [DW-1:0] rres;
  logic          bused;

  task automatic do_op(bit p, logic [1:0] o, logic [AW-1:0] a, logic [DW-1:0] w);
    bused = 0;
    if (!p) begin p0_op = o; p0_addr = a; p0_wdata = w; p0_req = 1; end
    else    begin p1_op = o; p1_addr = a; p1_wdata = w; p1_req = 1; end
    for (int k = 0; k < 20; k++) begin
      #1 bused |= mem_req;
      @(negedge clk);
      if (p ? p1_done : p0_done) break;
    end
    rres = p ? p1_rdata : p0_rdata;
    p0_req = 0; p1_req = 0;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic p; logic [1:0] op; logic [AW-1:0] a; logic [DW-1:0] w; logic [DW-1:0] r;
    logic v0; logic [DW-1:0] d0; logic v1; logic [DW-1:0] d1; logic [DW-1:0] m;
  } step_t;

  localparam step_t STEPS [5] = '{
    '{1'b0, 2'b00, 6'd5, 16'd0,  16'd10, 1'b1, 16'd10, 1'b0, 16'd0,  16'd10},
    '{1'b1, 2'b00, 6'd5, 16'd0,  16'd10, 1'b1, 16'd10, 1'b1, 16'd10, 16'd10},
    '{1'b1, 2'b01, 6'd5, 16'd12, 16'd0,  1'b0, 16'd0,  1'b1, 16'd12, 16'd12},
    '{1'b0, 2'b01, 6'd5, 16'd24, 16'd0,  1'b1, 16'd24, 1'b0, 16'd0,  16'd24},
    '{1'b1, 2'b00, 6'd5, 16'd0,  16'd24, 1'b1, 16'd24, 1'b1, 16'd24, 16'd24}
  };

  initial begin
    #200000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = DW'(100 + 7 * i);
    mem[5] = 10;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 p0_done", p0_done, 0);
    chk("R1 p1_done", p1_done, 0);
    chk("R1 mem_req", mem_req, 0);
    for (int a = 0; a < 8; a++) begin
      look(AW'(a));
      chk("R1 look_v0", look_v0, 0);
      chk("R1 look_v1", look_v1, 0);
    end

    // five-step shared-variable sequence: R2 R4 R5
    for (int s = 0; s < 5; s++) begin
      do_op(STEPS[s].p, STEPS[s].op, STEPS[s].a, STEPS[s].w);
      if (STEPS[s].op == 2'b00) chk("R2 load data", rres, STEPS[s].r);
      chk("R2 R4 bus used on miss/store", bused, 1);
      look(STEPS[s].a);
      chk("R5 cache0 state", look_v0, STEPS[s].v0);
      if (STEPS[s].v0) chk("R4 cache0 word", look_d0, STEPS[s].d0);
      chk("R5 cache1 state", look_v1, STEPS[s].v1);
      if (STEPS[s].v1) chk("R4 cache1 word", look_d1, STEPS[s].d1);
      chk("R4 memory word", mem[5], STEPS[s].m);
    end

    // R3 load hit
    do_op(0, 2'b00, 6'd5, 0);
    chk("R3 hit data", rres, 24);
    chk("R3 hit no bus", bused, 0);
    look(6'd5);
    chk("R3 still valid", look_v0, 1);

    // R8 alias store on same index
    do_op(1, 2'b00, 6'd6, 0);
    chk("R2 fill 6", rres, 142);
    do_op(0, 2'b01, 6'd2, 77);
    chk("R4 mem 2", mem[2], 77);
    look(6'd6);
    chk("R8 alias keeps line", look_v1, 1);
    chk("R8 alias word", look_d1, 142);
    look(6'd2);
    chk("R4 store miss alloc", look_v0, 1);

    // R6 evict
    do_op(1, 2'b10, 6'd6, 0);
    chk("R6 evict no bus", bused, 0);
    look(6'd6);
    chk("R6 evicted", look_v1, 0);
    do_op(0, 2'b11, 6'd6, 0);
    look(6'd2);
    chk("R6 tag mismatch keeps", look_v0, 1);
    do_op(1, 2'b00, 6'd6, 0);
    chk("R6 reload misses", bused, 1);
    chk("R6 reload data", rres, 142);

    // R7 contention, last grant was cache 1 -> cache 0 first
    p0_op = 0; p0_addr = 13; p0_req = 1;
    p1_op = 0; p1_addr = 10; p1_req = 1;
    @(negedge clk);
    chk("R7 c0 first done", p0_done, 1);
    chk("R7 c1 waits", p1_done, 0);
    chk("R7 c0 data", p0_rdata, 191);
    p0_req = 0;
    @(negedge clk);
    chk("R7 c1 next", p1_done, 1);
    chk("R7 c1 data", p1_rdata, 170);
    p1_req = 0;
    @(negedge clk);

    // cache 0 granted last -> cache 1 first
    do_op(0, 2'b00, 6'd20, 0);
    p0_op = 0; p0_addr = 33; p0_req = 1;
    p1_op = 0; p1_addr = 34; p1_req = 1;
    @(negedge clk);
    chk("R7 c1 first done", p1_done, 1);
    chk("R7 c0 waits", p0_done, 0);
    chk("R7 c1 data b", p1_rdata, 338);
    p1_req = 0;
    @(negedge clk);
    chk("R7 c0 next", p0_done, 1);
    chk("R7 c0 data b", p0_rdata, 331);
    p0_req = 0;
    @(negedge clk);

    // contending stores to one address: cache 1 first, cache 0 second
    p0_op = 1; p0_addr = 40; p0_wdata = 2222; p0_req = 1;
    p1_op = 1; p1_addr = 40; p1_wdata = 1111; p1_req = 1;
    @(negedge clk);
    chk("R7 store c1 first", p1_done, 1);
    p1_req = 0;
    @(negedge clk);
    chk("R7 store c0 second", p0_done, 1);
    p0_req = 0;
    @(negedge clk);
    chk("R7 mem later value", mem[40], 2222);
    look(6'd40);
    chk("R7 winner valid", look_v0, 1);
    chk("R7 winner word", look_d0, 2222);
    chk("R5 earlier writer invalid", look_v1, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule